// File: doc/BRIEF.md
# Four-Register Datapath with Slow Memory Port

This block is the execution core of a small processor with no instruction control of its own. An outside sequencer drives it one clock at a time. Two 2-bit selectors put any of four 16-bit registers onto the A and B operand buses. A 2-bit code picks the ALU function. A write-back enable, with its own selector, decides whether the result on the C bus lands in a register. The ALU evaluates on every clock, and its result is always visible on `alu_result`, even when write-back is off.

A separate transfer port moves one word between a register and a 32-word memory. It uses a valid/ready handshake. A request is taken on a clock edge where `xfer_valid` and `xfer_ready` are both high. `xfer_ready` stays low for the whole transfer, and a request held while it is low has no effect. The requester keeps its request up until it sees ready. The transfer completes a fixed number of cycles later, and the datapath keeps running in the meantime. A host write port fills memory words directly, in a single cycle.

Top module: `quad_reg_datapath`

## Requirements
- R1: After reset, every register and every memory word reads zero, `busy` is low and `xfer_ready` is high.
- R2: `alu_result` is a function of the current selectors and register contents, in the same cycle, whatever `c_en` is. For `alu_op`: 00 gives A+B, 01 gives A−B, 10 gives A AND B and 11 gives A OR B. Results are 16-bit and wrap.
- R3: The A and B selectors may name the same register. With R0 = 43 and add selected, `alu_result` is 86.
- R4: With `c_en` high, `alu_result` is written into register `c_sel` at the clock edge. With `c_en` low and no load completing, no register changes.
- R5: `xfer_ready` is high exactly when no transfer is pending. A request is accepted at an edge where `xfer_valid` and `xfer_ready` are both high. A request made while `xfer_ready` is low is ignored.
- R6: `busy` rises after the accepting edge and stays high for exactly LAT cycles (default 4). The transfer completes at the LAT-th edge after acceptance.
- R7: With `xfer_dir` = 0 (load), the memory word at `xfer_addr`, as it stands at completion, is written into register `xfer_reg`. With `xfer_dir` = 1 (store), the value register `xfer_reg` held at acceptance is written to memory at completion.
- R8: Register write-back through the C bus works normally while a transfer is pending.
- R9: When a load completes at the same edge as a C-bus write to the same register, the loaded word wins.
- R10: `host_we` writes `host_data` to word `host_addr` (5-bit, 0 to 31) at the edge. A store completing at the same address and edge takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 2 | Register driving the A bus |
| b_sel | input | 2 | Register driving the B bus |
| alu_op | input | 2 | ALU function code |
| c_en | input | 1 | C-bus write-back enable |
| c_sel | input | 2 | Write-back destination register |
| alu_result | output | 16 | Current ALU output |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_ready | output | 1 | Transfer port can accept a request |
| xfer_dir | input | 1 | 0 = memory to register, 1 = register to memory |
| xfer_reg | input | 2 | Register taking part in the transfer |
| xfer_addr | input | 5 | Memory word taking part in the transfer |
| busy | output | 1 | A transfer is pending |
| host_we | input | 1 | Direct memory write enable |
| host_addr | input | 5 | Direct write address |
| host_data | input | 16 | Direct write data |

## Verification
The ALU is driven with one register on both buses (doubling 43 to 86), with a subtraction whose B operand is negative, and with long random runs over all four functions and every selector pairing. These separate operand routing faults from function decode faults. Transfers are tried as a clean load, as a store whose source register changes after acceptance (this shows the value is captured at acceptance), and as a request held while the port is busy (this shows the request is dropped). A load is made to finish on the same edge as a C-bus write to the same register, which exposes the write priority. Write-backs are also issued during transfers, which shows that the datapath does not stall.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/qrd_alu.sv
module qrd_alu #(
  parameter int DW = 16
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  import qrd_pkg::*;
  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  always_comb begin
    unique case (op_e)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/qrd_regfile.sv
module qrd_regfile #(
  parameter int DW = 16,
  parameter int SW = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SW-1:0]              a_sel,
  input  logic [SW-1:0]              b_sel,
  output logic [DW-1:0]              a_data,
  output logic [DW-1:0]              b_data,
  input  logic                       c_en,
  input  logic [SW-1:0]              c_sel,
  input  logic [DW-1:0]              c_data,
  input  logic                       l_en,
  input  logic [SW-1:0]              l_sel,
  input  logic [DW-1:0]              l_data,
  output logic [(1<<SW)-1:0][DW-1:0] q
);
  localparam int NREG = 1 << SW;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                             q[r] <= '0;
      else if (l_en && l_sel == SW'(r))       q[r] <= l_data;
      else if (c_en && c_sel == SW'(r))       q[r] <= c_data;
    end
  end

  assign a_data = q[a_sel];
  assign b_data = q[b_sel];
endmodule

// File: rtl/qrd_membus.sv
module qrd_membus #(
  parameter int DW  = 16,
  parameter int AW  = 5,
  parameter int SW  = 2,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_dir,
  input  logic [SW-1:0] req_reg,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] st_data,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_data,
  output logic          ld_en,
  output logic [SW-1:0] ld_sel,
  output logic [DW-1:0] ld_data,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = (LAT > 1) ? $clog2(LAT) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic          busy_q;
  logic [CW-1:0] cnt;
  logic          cur_dir;
  logic [SW-1:0] cur_reg;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] snap;
  logic          done;
  logic          st_commit;

  assign done      = busy_q && (cnt == '0);
  assign st_commit = done && cur_dir;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                                   mem[w] <= '0;
      else if (st_commit && cur_addr == AW'(w))     mem[w] <= snap;
      else if (host_we && host_addr == AW'(w))      mem[w] <= host_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt      <= '0;
      cur_dir  <= 1'b0;
      cur_reg  <= '0;
      cur_addr <= '0;
      snap     <= '0;
    end else if (busy_q) begin
      if (cnt == '0) busy_q <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end else if (req_valid) begin
      busy_q   <= 1'b1;
      cnt      <= CW'(LAT - 1);
      cur_dir  <= req_dir;
      cur_reg  <= req_reg;
      cur_addr <= req_addr;
      snap     <= st_data;
    end
  end

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign ld_en     = done && !cur_dir;
  assign ld_sel    = cur_reg;
  assign ld_data   = mem[cur_addr];
endmodule

// File: rtl/quad_reg_datapath.sv
module quad_reg_datapath #(
  parameter int DW  = 16,
  parameter int AW  = 5,
  parameter int SW  = qrd_pkg::SEL_W,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] a_sel,
  input  logic [SW-1:0] b_sel,
  input  logic [1:0]    alu_op,
  input  logic          c_en,
  input  logic [SW-1:0] c_sel,
  output logic [DW-1:0] alu_result,
  input  logic          xfer_valid,
  output logic          xfer_ready,
  input  logic          xfer_dir,
  input  logic [SW-1:0] xfer_reg,
  input  logic [AW-1:0] xfer_addr,
  output logic          busy,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_data
);
  logic [DW-1:0]              a_bus, b_bus;
  logic [(1<<SW)-1:0][DW-1:0] rf_q;
  logic                       ld_en;
  logic [SW-1:0]              ld_sel;
  logic [DW-1:0]              ld_data;

  qrd_regfile #(.DW(DW), .SW(SW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .b_sel(b_sel), .a_data(a_bus), .b_data(b_bus),
    .c_en(c_en), .c_sel(c_sel), .c_data(alu_result),
    .l_en(ld_en), .l_sel(ld_sel), .l_data(ld_data),
    .q(rf_q)
  );

  qrd_alu #(.DW(DW)) u_alu (
    .op(alu_op), .a(a_bus), .b(b_bus), .y(alu_result)
  );

  qrd_membus #(.DW(DW), .AW(AW), .SW(SW), .LAT(LAT)) u_mb (
    .clk(clk), .rst_n(rst_n),
    .req_valid(xfer_valid), .req_ready(xfer_ready), .req_dir(xfer_dir),
    .req_reg(xfer_reg), .req_addr(xfer_addr), .st_data(rf_q[xfer_reg]),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .busy(busy)
  );
endmodule

// File: rtl/qrd_chk.sv
module qrd_chk #(
  parameter int DW  = 16,
  parameter int SW  = 2,
  parameter int LAT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       xfer_valid,
  input logic                       xfer_ready,
  input logic                       busy,
  input logic                       c_en,
  input logic [SW-1:0]              c_sel,
  input logic [DW-1:0]              alu_result,
  input logic [(1<<SW)-1:0][DW-1:0] rf_q,
  input logic                       ld_en,
  input logic [SW-1:0]              ld_sel
);
  logic [15:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R4
  c_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en && !(ld_en && ld_sel == c_sel)) |=> rf_q[$past(c_sel)] == $past(alu_result));

  // R4
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_en && !ld_en) |=> $stable(rf_q));

  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> busy);

  // R5
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !xfer_ready);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == 16'(LAT));
endmodule

bind quad_reg_datapath qrd_chk #(.DW(DW), .SW(SW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .busy(busy), .c_en(c_en), .c_sel(c_sel), .alu_result(alu_result),
  .rf_q(rf_q), .ld_en(ld_en), .ld_sel(ld_sel)
);

// File: tb/quad_reg_datapath_tb.sv
module quad_reg_datapath_tb;
  localparam int LAT = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [1:0]  a_sel, b_sel, alu_op, c_sel, xfer_reg;
  logic        c_en, xfer_valid, xfer_dir, host_we;
  logic [4:0]  xfer_addr, host_addr;
  logic [15:0] host_data, alu_result;
  logic        xfer_ready, busy;

  quad_reg_datapath #(.LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .b_sel(b_sel), .alu_op(alu_op),
    .c_en(c_en), .c_sel(c_sel), .alu_result(alu_result),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_dir(xfer_dir),
    .xfer_reg(xfer_reg), .xfer_addr(xfer_addr), .busy(busy),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data)
  );

  int vectors = 0;
  int errs = 0;
  bit finished = 0;

  logic [15:0] m_reg [4];
  logic [15:0] m_mem [32];
  bit          m_busy;
  int          m_cnt;
  bit          m_dir;
  logic [1:0]  m_rsel;
  logic [4:0]  m_addr;
  logic [15:0] m_snap;

  function automatic logic [15:0] f_alu(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    case (op)
      2'b00:   return a + b;
      2'b01:   return a - b;
      2'b10:   return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    m_busy = 0; m_cnt = 0; m_dir = 0; m_rsel = '0; m_addr = '0; m_snap = '0;
  endtask

  // One clock: drive, compare before the edge, then advance the model at the edge.
  task automatic step(string tag, logic [1:0] op, logic [1:0] a, logic [1:0] b,
                      bit ce, logic [1:0] cs, bit xv, bit xd, logic [1:0] xr,
                      logic [4:0] xa, bit hw, logic [4:0] ha, logic [15:0] hd,
                      int lit = -1);
    logic [15:0] old_reg [4];
    logic [15:0] old_mem [32];
    logic [15:0] y;
    @(negedge clk);
    alu_op = op; a_sel = a; b_sel = b; c_en = ce; c_sel = cs;
    xfer_valid = xv; xfer_dir = xd; xfer_reg = xr; xfer_addr = xa;
    host_we = hw; host_addr = ha; host_data = hd;
    #2;
    y = f_alu(op, m_reg[a], m_reg[b]);
    cmp(tag, alu_result, y);
    if (lit >= 0) cmp(tag, alu_result, 16'(lit));
    cmp("R5", {15'd0, xfer_ready}, {15'd0, !m_busy});
    cmp("R6", {15'd0, busy}, {15'd0, m_busy});
    @(posedge clk);
    old_reg = m_reg;
    old_mem = m_mem;
    if (hw) m_mem[ha] = hd;
    if (ce) m_reg[cs] = y;
    if (m_busy) begin
      if (m_cnt == 0) begin
        if (m_dir) m_mem[m_addr] = m_snap;
        else       m_reg[m_rsel] = old_mem[m_addr];
        m_busy = 0;
      end else m_cnt--;
    end else if (xv) begin
      m_busy = 1; m_cnt = LAT - 1;
      m_dir = xd; m_rsel = xr; m_addr = xa; m_snap = old_reg[xr];
    end
  endtask

  task automatic idle(string tag, logic [1:0] rd = 2'd0);
    step(tag, 2'b11, rd, rd, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic read_reg(string tag, logic [1:0] r, int lit);
    step(tag, 2'b11, r, r, 0, 0, 0, 0, 0, 0, 0, 0, 0, lit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    a_sel = 0; b_sel = 0; alu_op = 0; c_en = 0; c_sel = 0;
    xfer_valid = 0; xfer_dir = 0; xfer_reg = 0; xfer_addr = 0;
    host_we = 0; host_addr = 0; host_data = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset contents
    for (int r = 0; r < 4; r++) read_reg("R1", 2'(r), 0);
    step("R1", 2'b11, 0, 0, 0, 0, 1, 0, 2'd3, 5'd31, 0, 0, 0);
    repeat (LAT) idle("R1");
    read_reg("R1", 3, 0);

    // R10: host fills words 5, 6 and 0
    step("R10", 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'd5, 16'd43);
    step("R10", 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'd6, 16'hFED8);
    step("R10", 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'd0, 16'h1234);

    // R7: load R0 from word 5
    step("R7", 2'b11, 0, 0, 0, 0, 1, 0, 2'd0, 5'd5, 0, 0, 0);
    repeat (LAT) idle("R6");
    read_reg("R7", 0, 43);

    // R3: same register on both buses
    step("R3", 2'b00, 0, 0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 86);
    read_reg("R3", 2, 86);

    // R8 and R5: load R1 from word 6 while write-backs go on and a second request is dropped
    step("R7", 2'b11, 0, 0, 0, 0, 1, 0, 2'd1, 5'd6, 0, 0, 0);
    step("R8", 2'b00, 2, 0, 1, 2'd3, 0, 0, 0, 0, 0, 0, 0, 129);
    step("R5", 2'b11, 0, 0, 0, 0, 1, 1, 2'd0, 5'd9, 0, 0, 0);
    idle("R8");
    idle("R8");
    read_reg("R8", 3, 129);
    read_reg("R7", 1, 16'hFED8);

    // R2: subtraction A-B with a negative B
    step("R2", 2'b01, 0, 1, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 339);
    step("R2", 2'b01, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'hFEAD);
    step("R2", 2'b10, 3, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 129 & 339);

    // R5: the dropped store never reached word 9
    step("R5", 2'b11, 0, 0, 0, 0, 1, 0, 2'd3, 5'd9, 0, 0, 0);
    repeat (LAT) idle("R5");
    read_reg("R5", 3, 0);

    // R7: store R2 to word 31; R2 changes right after acceptance
    step("R7", 2'b11, 0, 0, 0, 0, 1, 1, 2'd2, 5'd31, 0, 0, 0);
    step("R7", 2'b00, 0, 0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 86);
    repeat (LAT - 1) idle("R7");
    step("R7", 2'b11, 0, 0, 0, 0, 1, 0, 2'd3, 5'd31, 0, 0, 0);
    repeat (LAT) idle("R7");
    read_reg("R7", 3, 339);

    // R10: host write and store completion on the same word and edge
    step("R10", 2'b11, 0, 0, 0, 0, 1, 1, 2'd0, 5'd7, 0, 0, 0);
    repeat (LAT - 1) idle("R10");
    step("R10", 2'b11, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'd7, 16'hBEEF);
    step("R10", 2'b11, 0, 0, 0, 0, 1, 0, 2'd1, 5'd7, 0, 0, 0);
    repeat (LAT) idle("R10");
    read_reg("R10", 1, 43);

    // R9: load completion and C write to the same register on one edge
    step("R9", 2'b11, 0, 0, 0, 0, 1, 0, 2'd2, 5'd0, 0, 0, 0);
    repeat (LAT - 1) idle("R9");
    step("R9", 2'b00, 0, 0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 86);
    read_reg("R9", 2, 16'h1234);

    // R2 and all others: random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      step("R2", 2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
           2'($urandom), ($urandom % 3) == 0, 1'($urandom), 2'($urandom),
           5'($urandom), ($urandom % 4) == 0, 5'($urandom), 16'($urandom));
    end
    for (int r = 0; r < 4; r++) idle("R4", 2'(r));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule